// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block turns an aligned stream of 5-bit code-groups into the nibble-wide receive side of the MII. The upstream logic handles clock recovery, NRZI decoding, descrambling and alignment. It delivers one code-group per 25 MHz cycle, with a strobe that marks each cycle in which the code-group is valid. The decoder finds the start-of-stream pair, turns each data code-group into its 4-bit value, and finds the end-of-stream pair. It reports errors in two distinct forms. A broken start delimiter raises the error flag with a fixed error nibble and leaves data-valid low. A bad code-group inside a frame raises the error flag with data-valid still high.

Code-groups are classified and tracked on the rising clock edge. The result is then re-registered on the falling edge, so the three MII outputs move only on falling edges and the MAC can sample them on rising edges.

Top module: `cgx_rx_decode`

## Requirements
- R1: While reset is held, and after it is released, rxd, rx_dv and rx_er are all 0 until a non-idle code-group is accepted.
- R2: Inside a frame, a data code-group gives rx_dv=1, rx_er=0 and rxd equal to its value. The sixteen codes for values 0 through F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: A start delimiter is J=11000 followed by K=10001. Both code-groups give rx_dv=0 and rx_er=0, and rx_dv first rises with the first data code-group after K.
- R4: End of stream is T=01101 followed by R=00111. The T cycle and the R cycle both give rx_dv=0 and rx_er=0, and the block then waits for idle (11111) or a new J.
- R5: Inside a frame, any code-group that is not data, T or idle (for example J, K, R or an unused code) gives rx_er=1 and rx_dv=1 for that cycle. rxd is unspecified, and the frame continues.
- R6: A bad start delimiter gives rx_er=1, rx_dv=0 and rxd=4'b1110. This covers J followed by anything but K, and any code-group other than J or idle while no frame is in progress.
- R7: After a bad start delimiter, rx_er=1, rx_dv=0 and rxd=1110 are held on every accepted code-group until an idle code-group is accepted. That idle clears all three outputs to 0.
- R8: An idle code-group inside a frame is a premature end. It gives rx_er=1 and rx_dv=1 for that cycle, and the next accepted code-group is decoded as outside a frame.
- R9: A T that is not followed by R gives rx_er=1 and rx_dv=1 on the following code-group, and the frame continues.
- R10: A cycle with cg_valid=0 changes neither the outputs nor the decoding state.
- R11: rxd, rx_dv and rx_er change only on falling clock edges. The values seen at a rising edge are the ones decided at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz receive clock; state on rising edge, outputs on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cg_valid | input | 1 | Marks cg_in as a valid code-group this cycle |
| cg_in | input | 5 | Aligned 5-bit code-group |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
The assertions assume that cg_in is settled at every rising edge, that cg_valid is a plain per-cycle qualifier, and that reset is held across at least one full clock period so the falling-edge stage clears as well. The bench changes its inputs shortly after a rising edge and holds them for the whole cycle. It asserts reset for several cycles before the first code-group. It compares the outputs once just before and once just after each falling edge, which separates the falling-edge timing from the decode result.

// File: rtl/cgx_pkg.sv
package cgx_pkg;

  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    CG_DATA, CG_J, CG_K, CG_T, CG_R, CG_IDLE, CG_BAD
  } cg_kind_t;

  typedef enum logic [2:0] {
    ST_WAIT, ST_GOT_J, ST_FRAME, ST_GOT_T, ST_BADSSD
  } rx_state_t;

  typedef struct packed {
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] nib;
  } mii_rx_t;

  localparam logic [NIB_W-1:0] SSD_ERR_NIB = 4'b1110;

endpackage

// File: rtl/cgx_classify.sv
module cgx_classify
  import cgx_pkg::*;
#(
  parameter int CW = CG_W,
  parameter int NW = NIB_W
) (
  input  logic [CW-1:0] code,
  output cg_kind_t      kind,
  output logic [NW-1:0] nib
);

  always_comb begin
    kind = CG_DATA;
    nib  = '0;
    case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      5'b11000: kind = CG_J;
      5'b10001: kind = CG_K;
      5'b01101: kind = CG_T;
      5'b00111: kind = CG_R;
      5'b11111: kind = CG_IDLE;
      default:  kind = CG_BAD;
    endcase
  end

endmodule

// File: rtl/cgx_track.sv
module cgx_track
  import cgx_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  cg_kind_t      kind,
  input  logic [NW-1:0] nib,
  output mii_rx_t       stage
);

  rx_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_WAIT;
      stage <= '0;
    end else if (valid) begin
      case (st)
        ST_WAIT: begin
          if (kind == CG_J) begin
            st <= ST_GOT_J;  stage <= '0;
          end else if (kind == CG_IDLE) begin
            stage <= '0;
          end else begin
            st <= ST_BADSSD; stage <= '{dv: 1'b0, er: 1'b1, nib: SSD_ERR_NIB};
          end
        end
        ST_GOT_J: begin
          if (kind == CG_K) begin
            st <= ST_FRAME;  stage <= '0;
          end else begin
            st <= ST_BADSSD; stage <= '{dv: 1'b0, er: 1'b1, nib: SSD_ERR_NIB};
          end
        end
        ST_FRAME: begin
          if (kind == CG_DATA) begin
            stage <= '{dv: 1'b1, er: 1'b0, nib: nib};
          end else if (kind == CG_T) begin
            st <= ST_GOT_T;  stage <= '0;
          end else if (kind == CG_IDLE) begin
            st <= ST_WAIT;   stage <= '{dv: 1'b1, er: 1'b1, nib: '0};
          end else begin
            stage <= '{dv: 1'b1, er: 1'b1, nib: '0};
          end
        end
        ST_GOT_T: begin
          if (kind == CG_R) begin
            st <= ST_WAIT;   stage <= '0;
          end else begin
            st <= ST_FRAME;  stage <= '{dv: 1'b1, er: 1'b1, nib: '0};
          end
        end
        default: begin
          if (kind == CG_IDLE) begin
            st <= ST_WAIT;   stage <= '0;
          end else begin
            stage <= '{dv: 1'b0, er: 1'b1, nib: SSD_ERR_NIB};
          end
        end
      endcase
    end
  end

  // R7
  badssd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BADSSD) |-> (stage.er && !stage.dv && stage.nib == SSD_ERR_NIB));

  // R3
  dv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stage.dv) |-> ($past(st) == ST_FRAME || $past(st) == ST_GOT_T));

  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(stage) && $stable(st)));

  // R8
  early_end_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && st == ST_FRAME && kind == CG_IDLE) |=> (stage.er && stage.dv && st == ST_WAIT));

endmodule

// File: rtl/cgx_fall_reg.sv
module cgx_fall_reg
  import cgx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  mii_rx_t d,
  output mii_rx_t q
);

  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R11
  fall_align_chk: assert property (@(posedge clk) disable iff (rst)
    q == d);

endmodule

// File: rtl/cgx_rx_decode.sv
module cgx_rx_decode
  import cgx_pkg::*;
#(
  parameter int CW = CG_W,
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cg_valid,
  input  logic [CW-1:0] cg_in,
  output logic [NW-1:0] rxd,
  output logic          rx_dv,
  output logic          rx_er
);

  cg_kind_t      kind;
  logic [NW-1:0] nib;
  mii_rx_t       stage;
  mii_rx_t       port_q;

  cgx_classify #(.CW(CW), .NW(NW)) u_cls (
    .code(cg_in), .kind(kind), .nib(nib)
  );

  cgx_track #(.NW(NW)) u_trk (
    .clk(clk), .rst(rst), .valid(cg_valid), .kind(kind), .nib(nib), .stage(stage)
  );

  cgx_fall_reg u_out (
    .clk(clk), .rst(rst), .d(stage), .q(port_q)
  );

  assign rxd   = port_q.nib;
  assign rx_dv = port_q.dv;
  assign rx_er = port_q.er;

  // R6
  ssd_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_er && !rx_dv) |-> (rxd == 4'b1110));

endmodule

// File: tb/sim_cgx_rx_decode.sv
module sim_cgx_rx_decode;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cg_valid = 1'b0;
  logic [4:0] cg_in = 5'b11111;
  logic [3:0] rxd;
  logic       rx_dv, rx_er;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cgx_rx_decode u0 (
    .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_in(cg_in),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111, X = 5'b00000;
  logic [4:0] dcode [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // reference model: 0 waiting, 1 after J, 2 in frame, 3 after T, 4 bad start
  int mode = 0;
  logic       e_dv = 0, e_er = 0;
  logic [3:0] e_rxd = 0;
  bit         e_care = 1;

  function automatic int data_val(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (dcode[n] == c) return n;
    return -1;
  endfunction

  task automatic model(input logic [4:0] c);
    int v = data_val(c);
    e_care = 1; e_dv = 0; e_er = 0; e_rxd = 0;
    if (mode == 0) begin
      if (c == J) mode = 1;
      else if (c != I) begin mode = 4; e_er = 1; e_rxd = 4'hE; end
    end else if (mode == 1) begin
      if (c == K) mode = 2;
      else begin mode = 4; e_er = 1; e_rxd = 4'hE; end
    end else if (mode == 2) begin
      if (v >= 0) begin e_dv = 1; e_rxd = v[3:0]; end
      else if (c == T) mode = 3;
      else begin e_dv = 1; e_er = 1; e_care = 0; if (c == I) mode = 0; end
    end else if (mode == 3) begin
      if (c == R) mode = 0;
      else begin mode = 2; e_dv = 1; e_er = 1; e_care = 0; end
    end else begin
      if (c == I) mode = 0;
      else begin e_er = 1; e_rxd = 4'hE; end
    end
  endtask

  task automatic check(input string req);
    total++;
    if (rx_dv !== e_dv || rx_er !== e_er || (e_care && rxd !== e_rxd)) begin
      bad++;
      $display("FAIL %s: got dv=%b er=%b rxd=%h, want dv=%b er=%b rxd=%h%s",
               req, rx_dv, rx_er, rxd, e_dv, e_er, e_rxd, e_care ? "" : " (rxd free)");
    end
  endtask

  // call at 7 time units after a rising edge
  task automatic send(input logic v, input logic [4:0] c, input string req);
    cg_valid = v;
    cg_in    = c;
    @(posedge clk);
    #3;
    check("R11");  // previous values still present before the falling edge
    if (v) model(c);
    #4;
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #7;
    check("R1");
    rst = 1'b0;
    send(1, I, "R1");
    send(1, I, "R1");
    // full frame with every data value
    send(1, J, "R3");
    send(1, K, "R3");
    for (int n = 0; n < 16; n++) send(1, dcode[n], "R2");
    send(1, T, "R4");
    send(1, R, "R4");
    send(1, I, "R4");
    // frame with illegal codes inside, plus gaps
    send(1, J, "R3");
    send(1, K, "R3");
    send(1, dcode[5], "R2");
    send(1, X, "R5");
    send(1, dcode[9], "R5");
    send(1, J, "R5");
    send(0, dcode[3], "R10");
    send(0, I, "R10");
    send(1, dcode[3], "R10");
    send(1, T, "R9");
    send(1, dcode[7], "R9");
    send(1, dcode[2], "R9");
    send(1, T, "R4");
    send(1, R, "R4");
    // premature end by idle
    send(1, J, "R3");
    send(1, K, "R3");
    send(1, dcode[10], "R2");
    send(1, I, "R8");
    send(1, I, "R8");
    send(1, dcode[1], "R6");
    // held bad start until idle
    send(1, dcode[4], "R7");
    send(0, I, "R10");
    send(1, J, "R7");
    send(1, I, "R7");
    send(1, I, "R7");
    // J followed by non-K
    send(1, J, "R3");
    send(1, J, "R6");
    send(1, K, "R7");
    send(1, I, "R7");
    send(1, J, "R3");
    send(1, I, "R6");
    send(1, I, "R7");
    // T followed by idle
    send(1, J, "R3");
    send(1, K, "R3");
    send(1, dcode[15], "R2");
    send(1, T, "R4");
    send(1, I, "R9");
    send(1, I, "R8");
    send(1, I, "R1");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no finish, want finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule